// File: doc/BRIEF.md
# Synthesizer Loop Power-Down Sequencer

This block decides when each phase-locked loop of a multi-loop frequency synthesizer may be taken out of operation and when it may come back. Each loop has two control bits from the programming registers: a power-down request and a charge-pump high-impedance bit. It also watches that loop's phase-detector pump-up and pump-down activity. The high-impedance bit selects how a shutdown is carried out. When it is low, the sequencer lets the charge-pump pulse in progress finish before the loop goes down. When it is high, the loop goes down at once.

While a loop is down, its reference and feedback dividers are held in reset. The dividers restart from zero together on a single clock edge, so the reference/feedback phase relationship at power-up is always the same. A status bit reports that a loop is down only once its dividers are actually in reset. Loops are fully independent of each other. The shared reference input buffer stays enabled as long as any loop is still running.

Parameters set the number of loops and whether the register bits and detector activity pass through a capture flop stage before the sequencer sees them. The default is no capture stage.

Top module: `pll_loop_pwrdn`

## Requirements
- R1: After reset every loop is running: `cp_en`=1, `cnt_rst`=0, `pd_stat`=0, and `ref_buf_en`=1.
- R2: With `pd_req` clear, setting `tri_req` drives `cp_hiz` high in the same cycle, without any clock edge. `cp_en` stays 1 and `cnt_rst` stays 0.
- R3: With `pd_req` and `tri_req` both high, `cnt_rst` is 1, `cp_en` is 0 and `cp_hiz` is 1 after the next rising edge. This holds whatever the pump-up and pump-down activity is.
- R4: With `pd_req`=1, `tri_req`=0 and pump-up or pump-down active, the loop enters a draining state after the next edge. In that state `cp_en`=0, `cp_hiz`=0 and `cnt_rst`=0. The loop goes down on the first edge that samples both pump signals inactive.
- R5: With `pd_req`=1, `tri_req`=0 and no pump activity, `cnt_rst` is 1 after the next rising edge.
- R6: From the first edge after a shutdown request, `cp_en` stays 0 for as long as the loop is draining or down, so no new pump pulse may start.
- R7: While draining, clearing `pd_req` returns the loop to running on the next edge. Setting `tri_req` instead takes the loop down on the next edge.
- R8: `pd_stat` rises one edge after `cnt_rst` rises, and it is never 1 while `cnt_rst` is 0.
- R9: Clearing `pd_req` while a loop is down drops `cnt_rst` and `pd_stat` and raises `cp_en`, all on the same next edge.
- R10: A request on one loop leaves every other loop's outputs unchanged.
- R11: `ref_buf_en` is 0 only when every loop has `cnt_rst`=1.
- R12: While a loop is down, changes of `tri_req` have no effect. The loop stays down with `cp_hiz`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_req | input | NUM_LOOPS | Per-loop power-down request bit |
| tri_req | input | NUM_LOOPS | Per-loop charge-pump high-impedance bit; also selects immediate shutdown |
| pfd_up | input | NUM_LOOPS | Per-loop phase-detector pump-up activity |
| pfd_dn | input | NUM_LOOPS | Per-loop phase-detector pump-down activity |
| cp_en | output | NUM_LOOPS | Per-loop permission for new charge-pump pulses |
| cp_hiz | output | NUM_LOOPS | Per-loop charge-pump high-impedance control |
| cnt_rst | output | NUM_LOOPS | Per-loop hold-in-reset for reference and feedback dividers |
| pd_stat | output | NUM_LOOPS | Per-loop powered-down status |
| ref_buf_en | output | 1 | Enable for the shared reference input buffer |

## Verification
The draining state is the hardest situation to reach. It needs a request with the high-impedance bit low while a pump pulse is already in progress. The bench holds pump-up active, then hands over to pump-down while the request stays set, to show that draining lasts until both pump signals are quiet. From the draining state it then applies the two exits: a request withdrawn while pump-down is still active, and the high-impedance bit raised mid-pulse. All loops going down at once is also produced, to show the reference buffer dropping only in that case.

// File: rtl/pll_pwrdn_pkg.sv
package pll_pwrdn_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_DRAIN = 2'd1,
      ST_DOWN  = 2'd2
   } loop_st_e;

   localparam int unsigned MAX_LOOPS = 8;

endpackage

// File: rtl/pll_pwrdn_fsm.sv
module pll_pwrdn_fsm
   import pll_pwrdn_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pd_i,
   input  logic tri_i,
   input  logic up_i,
   input  logic dn_i,
   output logic cp_en_o,
   output logic cp_hiz_o,
   output logic cnt_rst_o,
   output logic pd_stat_o
);

   loop_st_e st_q;
   loop_st_e st_d;
   logic     busy;
   logic     stat_q;

   assign busy = up_i | dn_i;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_RUN: begin
            if (pd_i) begin
               if (tri_i || !busy) st_d = ST_DOWN;
               else                st_d = ST_DRAIN;
            end
         end
         ST_DRAIN: begin
            if (!pd_i)                st_d = ST_RUN;
            else if (tri_i || !busy) st_d = ST_DOWN;
         end
         ST_DOWN: begin
            if (!pd_i) st_d = ST_RUN;
         end
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_RUN;
         stat_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         stat_q <= (st_q == ST_DOWN) && (st_d == ST_DOWN);
      end
   end

   assign cp_en_o   = (st_q == ST_RUN);
   assign cnt_rst_o = (st_q == ST_DOWN);
   assign cp_hiz_o  = tri_i | (st_q == ST_DOWN);
   assign pd_stat_o = stat_q;

endmodule

// File: rtl/pll_pwrdn_refgate.sv
module pll_pwrdn_refgate #(
   parameter int unsigned N = 2
) (
   input  logic [N-1:0] loop_rst_i,
   output logic         ref_en_o
);

   assign ref_en_o = ~(&loop_rst_i);

endmodule

// File: rtl/pll_loop_pwrdn.sv
module pll_loop_pwrdn
   import pll_pwrdn_pkg::*;
#(
   parameter int unsigned NUM_LOOPS  = 2,
   parameter int unsigned REG_INPUTS = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LOOPS-1:0] pd_req,
   input  logic [NUM_LOOPS-1:0] tri_req,
   input  logic [NUM_LOOPS-1:0] pfd_up,
   input  logic [NUM_LOOPS-1:0] pfd_dn,
   output logic [NUM_LOOPS-1:0] cp_en,
   output logic [NUM_LOOPS-1:0] cp_hiz,
   output logic [NUM_LOOPS-1:0] cnt_rst,
   output logic [NUM_LOOPS-1:0] pd_stat,
   output logic                 ref_buf_en
);

   localparam int unsigned CAP_W = 4 * NUM_LOOPS;

   generate
      if (NUM_LOOPS < 1 || NUM_LOOPS > MAX_LOOPS) begin : g_bad_loops
         $error("pll_loop_pwrdn: NUM_LOOPS out of range");
      end
      if (REG_INPUTS > 1) begin : g_bad_reg
         $error("pll_loop_pwrdn: REG_INPUTS must be 0 or 1");
      end
   endgenerate

   logic [CAP_W-1:0]     cap_raw;
   logic [CAP_W-1:0]     cap_out;
   logic [NUM_LOOPS-1:0] pd_c;
   logic [NUM_LOOPS-1:0] tri_c;
   logic [NUM_LOOPS-1:0] up_c;
   logic [NUM_LOOPS-1:0] dn_c;

   assign cap_raw = {pfd_dn, pfd_up, tri_req, pd_req};

   generate
      if (REG_INPUTS == 1) begin : g_cap_reg
         logic [CAP_W-1:0] cap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cap_q <= '0;
            else        cap_q <= cap_raw;
         end
         assign cap_out = cap_q;
      end else begin : g_cap_wire
         assign cap_out = cap_raw;
      end
   endgenerate

   assign pd_c  = cap_out[0*NUM_LOOPS +: NUM_LOOPS];
   assign tri_c = cap_out[1*NUM_LOOPS +: NUM_LOOPS];
   assign up_c  = cap_out[2*NUM_LOOPS +: NUM_LOOPS];
   assign dn_c  = cap_out[3*NUM_LOOPS +: NUM_LOOPS];

   generate
      for (genvar gi = 0; gi < NUM_LOOPS; gi++) begin : g_loop
         pll_pwrdn_fsm i_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .pd_i      (pd_c[gi]),
            .tri_i     (tri_c[gi]),
            .up_i      (up_c[gi]),
            .dn_i      (dn_c[gi]),
            .cp_en_o   (cp_en[gi]),
            .cp_hiz_o  (cp_hiz[gi]),
            .cnt_rst_o (cnt_rst[gi]),
            .pd_stat_o (pd_stat[gi])
         );
      end
   endgenerate

   pll_pwrdn_refgate #(.N(NUM_LOOPS)) i_refgate (
      .loop_rst_i (cnt_rst),
      .ref_en_o   (ref_buf_en)
   );

endmodule

// File: rtl/pll_loop_pwrdn_chk.sv
module pll_loop_pwrdn_chk #(
   parameter int unsigned NUM_LOOPS = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LOOPS-1:0] pd_c,
   input logic [NUM_LOOPS-1:0] tri_c,
   input logic [NUM_LOOPS-1:0] up_c,
   input logic [NUM_LOOPS-1:0] dn_c,
   input logic [NUM_LOOPS-1:0] cp_en,
   input logic [NUM_LOOPS-1:0] cp_hiz,
   input logic [NUM_LOOPS-1:0] cnt_rst,
   input logic [NUM_LOOPS-1:0] pd_stat,
   input logic                 ref_buf_en
);

   generate
      for (genvar gi = 0; gi < NUM_LOOPS; gi++) begin : g_chk
         AST_TRI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            tri_c[gi] |-> cp_hiz[gi]); // R2
         AST_ASYNC_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (pd_c[gi] && tri_c[gi]) |=> (cnt_rst[gi] && !cp_en[gi] && cp_hiz[gi])); // R3
         AST_DRAIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
            (pd_c[gi] && !tri_c[gi] && (up_c[gi] || dn_c[gi]) && !cnt_rst[gi]) |=> !cnt_rst[gi]); // R4
         AST_SYNC_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (pd_c[gi] && !tri_c[gi] && !up_c[gi] && !dn_c[gi]) |=> cnt_rst[gi]); // R5
         AST_NO_NEW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            pd_c[gi] |=> !cp_en[gi]); // R6
         AST_STAT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pd_stat[gi]) |-> $past(cnt_rst[gi])); // R8
         AST_STAT_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
            pd_stat[gi] |-> cnt_rst[gi]); // R8
         AST_CLEAN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_rst[gi] && !pd_c[gi]) |=> (!cnt_rst[gi] && !pd_stat[gi] && cp_en[gi])); // R9
      end
   endgenerate

   AST_REF_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_en != '0) |-> ref_buf_en); // R11

endmodule

bind pll_loop_pwrdn pll_loop_pwrdn_chk #(.NUM_LOOPS(NUM_LOOPS)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pd_c       (pd_c),
   .tri_c      (tri_c),
   .up_c       (up_c),
   .dn_c       (dn_c),
   .cp_en      (cp_en),
   .cp_hiz     (cp_hiz),
   .cnt_rst    (cnt_rst),
   .pd_stat    (pd_stat),
   .ref_buf_en (ref_buf_en)
);

// File: tb/test_pll_loop_pwrdn.sv
`timescale 1ns/1ps
module test_pll_loop_pwrdn;

   localparam int N = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pd_req = '0;
   logic [N-1:0] tri_req = '0;
   logic [N-1:0] pfd_up = '0;
   logic [N-1:0] pfd_dn = '0;
   logic [N-1:0] cp_en;
   logic [N-1:0] cp_hiz;
   logic [N-1:0] cnt_rst;
   logic [N-1:0] pd_stat;
   logic         ref_buf_en;

   always #4 clk = ~clk;

   pll_loop_pwrdn #(.NUM_LOOPS(N)) i_pll_loop_pwrdn (
      .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .tri_req(tri_req),
      .pfd_up(pfd_up), .pfd_dn(pfd_dn), .cp_en(cp_en), .cp_hiz(cp_hiz),
      .cnt_rst(cnt_rst), .pd_stat(pd_stat), .ref_buf_en(ref_buf_en)
   );

   typedef struct {
      int       loop;
      bit [4:0] exp;
      string    tag;
   } item_t;

   item_t q[$];
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // expected field order: {cp_en, cp_hiz, cnt_rst, pd_stat, ref_buf_en}
   task automatic push(input int l, input bit [4:0] e, input string tag);
      item_t it;
      it.loop = l; it.exp = e; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic edge1();
      @(posedge clk); #1;
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk); #2;
         while (q.size() > 0) begin
            item_t it;
            bit [4:0] act;
            it = q.pop_front();
            act = {cp_en[it.loop], cp_hiz[it.loop], cnt_rst[it.loop],
                   pd_stat[it.loop], ref_buf_en};
            total++;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s loop%0d {en,hiz,rst,stat,ref} actual=%b expected=%b",
                        it.tag, it.loop, act, it.exp);
            end
         end
      end
   end

   initial begin : watchdog
      #100000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      edge1();
      push(0, 5'b10001, "R1");
      push(1, 5'b10001, "R1");
      // R2: tri alone
      @(negedge clk); tri_req[0] = 1'b1;
      edge1(); push(0, 5'b11001, "R2");
      // R5: synchronous, no pulse in flight
      @(negedge clk); tri_req[0] = 1'b0; pd_req[0] = 1'b1;
      edge1(); push(0, 5'b01101, "R5"); push(1, 5'b10001, "R10");
      edge1(); push(0, 5'b01111, "R8");
      // R12: tri changes while down
      @(negedge clk); tri_req[0] = 1'b1;
      edge1(); push(0, 5'b01111, "R12");
      @(negedge clk); tri_req[0] = 1'b0;
      edge1(); push(0, 5'b01111, "R12");
      // R9: release
      @(negedge clk); pd_req[0] = 1'b0;
      edge1(); push(0, 5'b10001, "R9");
      // R4 / R6: drain across up then down activity
      @(negedge clk); pfd_up[0] = 1'b1; pd_req[0] = 1'b1;
      edge1(); push(0, 5'b00001, "R4");
      @(negedge clk); pfd_up[0] = 1'b0; pfd_dn[0] = 1'b1;
      edge1(); push(0, 5'b00001, "R6");
      @(negedge clk); pfd_dn[0] = 1'b0;
      edge1(); push(0, 5'b01101, "R4");
      edge1(); push(0, 5'b01111, "R8");
      @(negedge clk); pd_req[0] = 1'b0;
      edge1(); push(0, 5'b10001, "R9");
      // R7: withdraw request while draining
      @(negedge clk); pfd_dn[0] = 1'b1; pd_req[0] = 1'b1;
      edge1(); push(0, 5'b00001, "R7");
      @(negedge clk); pd_req[0] = 1'b0;
      edge1(); push(0, 5'b10001, "R7");
      // R7: escalate to immediate while draining
      @(negedge clk); pd_req[0] = 1'b1;
      edge1(); push(0, 5'b00001, "R7");
      @(negedge clk); tri_req[0] = 1'b1;
      edge1(); push(0, 5'b01101, "R7");
      @(negedge clk); pd_req[0] = 1'b0; tri_req[0] = 1'b0; pfd_dn[0] = 1'b0;
      edge1(); push(0, 5'b10001, "R9");
      // R3: immediate shutdown with pulse active
      @(negedge clk); pfd_up[0] = 1'b1; pd_req[0] = 1'b1; tri_req[0] = 1'b1;
      edge1(); push(0, 5'b01101, "R3"); push(1, 5'b10001, "R10");
      edge1(); push(0, 5'b01111, "R8");
      // R11: both loops down
      @(negedge clk); pd_req[1] = 1'b1; tri_req[1] = 1'b1;
      edge1(); push(1, 5'b01100, "R11"); push(0, 5'b01110, "R11");
      @(negedge clk); pd_req[0] = 1'b0; tri_req[0] = 1'b0; pfd_up[0] = 1'b0;
      edge1(); push(0, 5'b10001, "R11"); push(1, 5'b01111, "R10");
      @(negedge clk); pd_req[1] = 1'b0; tri_req[1] = 1'b0;
      edge1(); push(1, 5'b10001, "R9");
      edge1();
      #3;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule